// File: doc/BRIEF.md
# Single-Transfer AHB Target with Burst Refusal

This block is an AHB bus target that fronts a small word-organised storage array and serves single transfers only. Each address phase that the bus accepts is registered: select, transfer kind, address, write flag and size. In the following data phase the block returns read data or writes the bus write data, using byte lanes decoded from the size and the low address bits. NONSEQ transfers are performed, and a configurable number of wait states may be inserted before they complete. IDLE and BUSY transfers, and cycles where the block is not selected, get an immediate OKAY.

A SEQ beat is refused. The block answers it with a two-cycle rejection, so the master must re-arbitrate and repeat the access as a NONSEQ transfer. One parameter turns the rejection code from RETRY into ERROR. A second parameter makes the block accept SEQ exactly as NONSEQ. The block never answers SPLIT. Storage size is set by `DEPTH`, and the byte address width is derived from it. Upper address bits do not exist, so every address maps to a storage word.

Top module: `ahb_nsq_target`

## Requirements
- R1: After reset, `readyout_o` is 1, `resp_o` is OKAY (2'b00) and every storage word reads as zero.
- R2: While `ready_i` is 0, no address phase is captured. A transfer that is presented only while `ready_i` is low never reaches storage, and the target's response does not change because of it.
- R3: An address phase that is IDLE (`trans_i`=2'b00) or BUSY (2'b01), or one in which `sel_i` is 0, is answered in the next cycle with `readyout_o` 1 and OKAY, and storage is not touched.
- R4: A selected NONSEQ (2'b10) write updates only the byte lanes picked by `size_i` (0 byte, 1 halfword, 2 or more full word) at the offset given by the low address bits, aligned down to the size.
- R5: A selected NONSEQ read returns the addressed word on `rdata_o` during its data phase, with OKAY. Outside a read data phase `rdata_o` is zero.
- R6: Back-to-back NONSEQ transfers with no idle cycle between them are all performed in order. With no wait states configured, each one completes in a single cycle, and a read sees a write issued just before it.
- R7: A selected SEQ (2'b11) transfer accepted with `ready_i` high is not performed. It is answered first with `readyout_o` 0 and RETRY (2'b10), then with `readyout_o` 1 and RETRY.
- R8: With `REJECT_AS_ERROR`=1, the same two-cycle refusal uses ERROR (2'b01) instead of RETRY.
- R9: With `SEQ_AS_NONSEQ`=1, a SEQ transfer is performed exactly like a NONSEQ transfer.
- R10: With `WAIT_STATES`=N, a performed transfer holds `readyout_o` low for exactly N cycles with OKAY, then completes.
- R11: A BUSY address phase followed directly by an IDLE one is answered with two zero-wait OKAY replies.
- R12: `resp_o` never carries SPLIT (2'b11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_i | input | 1 | Target selected in the current address phase |
| trans_i | input | 2 | Transfer kind: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| addr_i | input | ADDR_W | Byte address, ADDR_W = log2(DATA_W/8) + log2(DEPTH) |
| write_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 3 | Transfer size as log2 of the byte count |
| wdata_i | input | DATA_W | Write data, valid in the data phase |
| ready_i | input | 1 | Bus ready: the previous data phase completes and the address phase is taken |
| rdata_o | output | DATA_W | Read data in a read data phase, zero otherwise |
| readyout_o | output | 1 | Target ready: low while stalling or during the first refusal cycle |
| resp_o | output | 2 | Response: OKAY 00, ERROR 01, RETRY 10 |

## Verification
The assertions check the following properties every cycle: the refusal always takes two cycles with the same code in both; a refused beat triggers that sequence at once; idle-type phases are answered in zero wait; wait states appear when configured; a stalled bus freezes the captured address phase; no write ever happens while a refusal is being driven; and SPLIT never appears. Data-level correctness has to come from the bench's scenarios. This covers byte-lane merging, read-after-write across a pipelined sequence, the fact that refused and stalled transfers leave storage untouched, and the three parameter variants running side by side on one shared bus. The bench's cycle model is compared against all three instances on every clock.

// File: rtl/ahb_nsq_pkg.sv
package ahb_nsq_pkg;

  // transfer kinds as encoded on the bus
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  // response codes as encoded on the bus
  typedef enum logic [1:0] {
    RS_OKAY  = 2'b00,
    RS_ERROR = 2'b01,
    RS_RETRY = 2'b10,
    RS_SPLIT = 2'b11
  } resp_e;

  // data-phase states of the response machine
  typedef enum logic [1:0] {
    PH_OPEN  = 2'b00,
    PH_STALL = 2'b01,
    PH_REJ_A = 2'b10,
    PH_REJ_B = 2'b11
  } phase_e;

  // control captured from an accepted address phase
  typedef struct packed {
    logic       valid;
    logic       write;
    logic [2:0] size;
  } dp_ctrl_t;

endpackage

// File: rtl/nsq_addr_stage.sv
module nsq_addr_stage
  import ahb_nsq_pkg::*;
#(
  parameter int ADDR_W        = 6,
  parameter bit SEQ_AS_NONSEQ = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [1:0]        trans_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic              ready_i,
  output logic              accept_o,
  output logic              reject_o,
  output dp_ctrl_t          ctrl_o,
  output logic [ADDR_W-1:0] addr_o
);

  trans_e tr_kind;
  logic   is_seq;
  logic   is_nonseq;

  dp_ctrl_t          ctrl_q, ctrl_n;
  logic [ADDR_W-1:0] addr_q, addr_n;

  assign tr_kind   = trans_e'(trans_i);
  assign is_seq    = (tr_kind == TR_SEQ);
  assign is_nonseq = (tr_kind == TR_NONSEQ);

  // work is taken on only when the bus moves on to this address phase
  assign accept_o = ready_i && sel_i && (is_nonseq || (SEQ_AS_NONSEQ && is_seq));
  assign reject_o = ready_i && sel_i && is_seq && !SEQ_AS_NONSEQ;

  always_comb begin
    ctrl_n = ctrl_q;
    addr_n = addr_q;
    if (ready_i) begin
      ctrl_n.valid = accept_o;
      ctrl_n.write = write_i;
      ctrl_n.size  = size_i;
      addr_n       = addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      addr_q <= addr_n;
    end
  end

  assign ctrl_o = ctrl_q;
  assign addr_o = addr_q;

  // R2: a stalled bus leaves the captured address phase untouched
  a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> ($stable(ctrl_q) && $stable(addr_q)));

  // R7: a refused beat never becomes a pending data phase
  a_r7_refused_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |=> !ctrl_o.valid);

endmodule

// File: rtl/nsq_resp_fsm.sv
module nsq_resp_fsm
  import ahb_nsq_pkg::*;
#(
  parameter int WAIT_STATES     = 0,
  parameter bit REJECT_AS_ERROR = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready_i,
  input  logic       accept_i,
  input  logic       reject_i,
  output logic       readyout_o,
  output logic [1:0] resp_o
);

  localparam int    CNT_W    = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
  localparam int    LOAD_INT = (WAIT_STATES > 0) ? WAIT_STATES - 1 : 0;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOAD_INT);
  localparam resp_e REJ_CODE = REJECT_AS_ERROR ? RS_ERROR : RS_RETRY;

  phase_e           st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    st_n = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      PH_OPEN, PH_REJ_B: begin
        if (ready_i) begin
          if (reject_i) begin
            st_n = PH_REJ_A;
          end else if (accept_i && (WAIT_STATES > 0)) begin
            st_n  = PH_STALL;
            cnt_n = CNT_LOAD;
          end else begin
            st_n = PH_OPEN;
          end
        end
      end
      PH_STALL: begin
        if (cnt_q == '0) st_n = PH_OPEN;
        else             cnt_n = cnt_q - 1'b1;
      end
      PH_REJ_A: st_n = PH_REJ_B;
      default:  st_n = PH_OPEN;
    endcase
  end

  assign cnt_en = (cnt_n != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PH_OPEN;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign readyout_o = (st_q == PH_OPEN) || (st_q == PH_REJ_B);
  assign resp_o     = ((st_q == PH_REJ_A) || (st_q == PH_REJ_B)) ? REJ_CODE : RS_OKAY;

  // R7: the low refusal beat is always followed by a high one with the same code
  a_r7_second_refusal_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!readyout_o && resp_o != RS_OKAY) |=> (readyout_o && resp_o == $past(resp_o)));

  // R7 / R8: a refused beat starts the refusal at once with the configured code
  a_r8_refusal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (readyout_o && reject_i) |=> (!readyout_o && resp_o == REJ_CODE));

  // R3: idle-type phases get a zero-wait OKAY
  a_r3_idle_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (readyout_o && ready_i && !accept_i && !reject_i) |=> (readyout_o && resp_o == RS_OKAY));

  // R12: SPLIT is never driven
  a_r12_no_split: assert property (@(posedge clk) disable iff (!rst_n)
    resp_o != RS_SPLIT);

  if (WAIT_STATES > 0) begin : g_wait_chk
    // R10: a performed transfer is stretched with OKAY
    a_r10_wait_inserted: assert property (@(posedge clk) disable iff (!rst_n)
      (readyout_o && ready_i && accept_i) |=> (!readyout_o && resp_o == RS_OKAY));
  end else begin : g_nowait_chk
    // R6: with no wait states a performed transfer completes in one cycle
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (readyout_o && ready_i && accept_i) |=> (readyout_o && resp_o == RS_OKAY));
  end

endmodule

// File: rtl/nsq_store.sv
module nsq_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]             idx;
  logic [NB-1:0]                lane_en;
  logic [DEPTH-1:0][DATA_W-1:0] words;
  int                           span;
  int                           base;

  assign idx = addr_i[OFF_W +: IDX_W];

  // byte lanes: span from size, base aligned down to the span
  always_comb begin
    span = (int'(size_i) >= OFF_W) ? NB : (1 << size_i);
    base = int'(addr_i[OFF_W-1:0]) & ~(span - 1);
    for (int b = 0; b < NB; b++) begin
      lane_en[b] = (b >= base) && (b < base + span);
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    assign hit = we_i && (idx == IDX_W'(w));
    for (genvar b = 0; b < NB; b++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 byte_q <= '0;
        else if (hit && lane_en[b]) byte_q <= wdata_i[8*b +: 8];
      end
      assign words[w][8*b +: 8] = byte_q;
    end
  end

  assign rdata_o = words[idx];

  // R4: every write enables at least one lane
  a_r4_lane_picked: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (lane_en != '0));

endmodule

// File: rtl/ahb_nsq_target.sv
module ahb_nsq_target
  import ahb_nsq_pkg::*;
#(
  parameter int DATA_W          = 32,
  parameter int DEPTH           = 16,
  parameter int WAIT_STATES     = 0,
  parameter bit REJECT_AS_ERROR = 1'b0,
  parameter bit SEQ_AS_NONSEQ   = 1'b0,
  localparam int ADDR_W         = $clog2(DATA_W / 8) + $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [1:0]        trans_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              readyout_o,
  output logic [1:0]        resp_o
);

  logic              accept;
  logic              reject;
  dp_ctrl_t          dp_ctrl;
  logic [ADDR_W-1:0] dp_addr;
  logic              store_we;
  logic [DATA_W-1:0] store_rdata;

  nsq_addr_stage #(
    .ADDR_W        (ADDR_W),
    .SEQ_AS_NONSEQ (SEQ_AS_NONSEQ)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel_i),
    .trans_i  (trans_i),
    .addr_i   (addr_i),
    .write_i  (write_i),
    .size_i   (size_i),
    .ready_i  (ready_i),
    .accept_o (accept),
    .reject_o (reject),
    .ctrl_o   (dp_ctrl),
    .addr_o   (dp_addr)
  );

  nsq_resp_fsm #(
    .WAIT_STATES     (WAIT_STATES),
    .REJECT_AS_ERROR (REJECT_AS_ERROR)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (ready_i),
    .accept_i   (accept),
    .reject_i   (reject),
    .readyout_o (readyout_o),
    .resp_o     (resp_o)
  );

  // a write lands when its data phase completes on the bus
  assign store_we = dp_ctrl.valid && dp_ctrl.write && readyout_o && ready_i;

  nsq_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (store_we),
    .addr_i  (dp_addr),
    .size_i  (dp_ctrl.size),
    .wdata_i (wdata_i),
    .rdata_o (store_rdata)
  );

  assign rdata_o = (dp_ctrl.valid && !dp_ctrl.write) ? store_rdata : '0;

  // R7: storage is never written while a refusal is on the bus
  a_r7_refusal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_o != RS_OKAY) |-> !store_we);

  // R2: nothing is written while the bus is stalled
  a_r2_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |-> !store_we);

endmodule

// File: tb/ahb_nsq_target_tb_top.sv
module ahb_nsq_target_tb_top;

  localparam int CLK_PERIOD = 10;

  localparam logic [1:0] T_IDLE = 2'b00;
  localparam logic [1:0] T_BUSY = 2'b01;
  localparam logic [1:0] T_NSEQ = 2'b10;
  localparam logic [1:0] T_SEQ  = 2'b11;

  logic        clk;
  logic        rst_n;
  logic [2:0]  sel_bus;
  logic [1:0]  trans;
  logic [5:0]  addr;
  logic        write;
  logic [2:0]  size;
  logic [31:0] wdata;
  logic        stall;
  logic        hready_bus;
  logic [2:0]  ro;
  logic [1:0]  rs [3];
  logic [31:0] rd [3];
  int          owner;

  int    checks;
  int    errors;
  string cur_req;
  bit    run_cmp;

  logic [31:0] nxt_wdata;
  logic [31:0] prev_rdata;
  logic [1:0]  prev_resp;
  logic [1:0]  first_resp;
  int          waits;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // target 0: RETRY, no wait; target 1: ERROR, two waits; target 2: SEQ accepted, one wait
  ahb_nsq_target #(.DATA_W(32), .DEPTH(16), .WAIT_STATES(0), .REJECT_AS_ERROR(1'b0), .SEQ_AS_NONSEQ(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_bus[0]), .trans_i(trans), .addr_i(addr), .write_i(write),
    .size_i(size), .wdata_i(wdata), .ready_i(hready_bus), .rdata_o(rd[0]), .readyout_o(ro[0]), .resp_o(rs[0]));

  ahb_nsq_target #(.DATA_W(32), .DEPTH(16), .WAIT_STATES(2), .REJECT_AS_ERROR(1'b1), .SEQ_AS_NONSEQ(1'b0)) dut_err_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_bus[1]), .trans_i(trans), .addr_i(addr), .write_i(write),
    .size_i(size), .wdata_i(wdata), .ready_i(hready_bus), .rdata_o(rd[1]), .readyout_o(ro[1]), .resp_o(rs[1]));

  ahb_nsq_target #(.DATA_W(32), .DEPTH(16), .WAIT_STATES(1), .REJECT_AS_ERROR(1'b0), .SEQ_AS_NONSEQ(1'b1)) dut_seq_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_bus[2]), .trans_i(trans), .addr_i(addr), .write_i(write),
    .size_i(size), .wdata_i(wdata), .ready_i(hready_bus), .rdata_o(rd[2]), .readyout_o(ro[2]), .resp_o(rs[2]));

  // shared bus ready: data-phase owner's ready, forced low by an external stall
  always_comb begin
    if (owner < 0) hready_bus = !stall;
    else           hready_bus = ro[owner[1:0]] && !stall;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= -1;
    else if (hready_bus) owner <= sel_bus[0] ? 0 : (sel_bus[1] ? 1 : (sel_bus[2] ? 2 : -1));
  end

  // behavioural reference per target, compared every cycle
  for (genvar k = 0; k < 3; k++) begin : g_ref
    localparam int WT   = (k == 1) ? 2 : ((k == 2) ? 1 : 0);
    localparam bit ERRM = (k == 1);
    localparam bit SQOK = (k == 2);

    logic [31:0] mm [16];
    int          busy;
    int          rej;
    bit          pv;
    bit          pw;
    logic [5:0]  pa;
    logic [2:0]  ps;
    bit          e_ready;
    logic [1:0]  e_resp;
    logic [31:0] e_rd;

    always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < 16; i++) mm[i] = '0;
        busy = 0; rej = 0; pv = 0; pw = 0; pa = '0; ps = '0;
      end else begin
        e_ready = (busy == 0) && (rej != 2);
        if (e_ready && hready_bus && pv && pw) begin
          int span;
          int base;
          span = (ps >= 3'd2) ? 4 : (1 << ps);
          base = int'(pa[1:0]) & ~(span - 1);
          for (int b = 0; b < 4; b++)
            if (b >= base && b < base + span) mm[pa[5:2]][8*b +: 8] = wdata[8*b +: 8];
        end
        if (rej == 2) rej = 1;
        else if (busy > 0) busy = busy - 1;
        else if (hready_bus) begin
          pv = 0; rej = 0;
          if (sel_bus[k] && (trans == T_NSEQ || (trans == T_SEQ && SQOK))) begin
            pv = 1; pw = write; pa = addr; ps = size; busy = WT;
          end else if (sel_bus[k] && trans == T_SEQ) begin
            rej = 2;
          end
        end
      end
    end

    always @(negedge clk) begin
      if (rst_n && run_cmp) begin
        e_ready = (busy == 0) && (rej != 2);
        e_resp  = (rej > 0) ? (ERRM ? 2'b01 : 2'b10) : 2'b00;
        e_rd    = (pv && !pw) ? mm[pa[5:2]] : 32'h0;
        checks++;
        if (ro[k] !== e_ready) begin
          errors++;
          $display("FAIL %s target %0d readyout actual=%b expected=%b", cur_req, k, ro[k], e_ready);
        end
        checks++;
        if (rs[k] !== e_resp) begin
          errors++;
          $display("FAIL %s target %0d resp actual=%b expected=%b", cur_req, k, rs[k], e_resp);
        end
        checks++;
        if (rd[k] !== e_rd) begin
          errors++;
          $display("FAIL %s/R5 target %0d rdata actual=%h expected=%h", cur_req, k, rd[k], e_rd);
        end
        checks++;
        if (rs[k] === 2'b11) begin
          errors++;
          $display("FAIL R12 target %0d resp actual=%b expected=not 11", k, rs[k]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one address phase; records the completion of the previous data phase
  task automatic xfer(input int k, input logic [1:0] tr, input logic [5:0] a,
                      input logic wr, input logic [2:0] sz, input logic [31:0] wd);
    @(negedge clk);
    wdata     = nxt_wdata;
    nxt_wdata = wd;
    sel_bus   = (k < 0) ? 3'b000 : 3'(1 << k);
    trans = tr; addr = a; write = wr; size = sz;
    waits = 0;
    first_resp = (owner < 0) ? 2'b00 : rs[owner[1:0]];
    while (!hready_bus) begin
      waits++;
      @(negedge clk);
    end
    prev_rdata = (owner < 0) ? 32'h0 : rd[owner[1:0]];
    prev_resp  = (owner < 0) ? 2'b00 : rs[owner[1:0]];
    @(posedge clk);
  endtask

  task automatic idle_bus();
    xfer(-1, T_IDLE, 6'h00, 1'b0, 3'd0, 32'h0);
  endtask

  task automatic rd_chk(input int k, input logic [5:0] a, input logic [31:0] exp, input string tag);
    xfer(k, T_NSEQ, a, 1'b0, 3'd2, 32'h0);
    idle_bus();
    chk({tag, " read data"}, prev_rdata, exp);
    chk({tag, " read resp"}, 32'(prev_resp), 32'h0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; run_cmp = 0; cur_req = "R1";
    rst_n = 1'b0; sel_bus = '0; trans = T_IDLE; addr = '0; write = 1'b0;
    size = 3'd0; wdata = '0; stall = 1'b0; nxt_wdata = '0;
    prev_rdata = '0; prev_resp = '0; first_resp = '0; waits = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 readyout", 32'(ro), 32'h7);
    chk("R1 resp0", 32'(rs[0]), 32'h0);
    chk("R1 resp1", 32'(rs[1]), 32'h0);
    chk("R1 rdata", rd[0], 32'h0);
    run_cmp = 1;
    rd_chk(0, 6'h04, 32'h0, "R1");

    // R4: lane-masked writes, back to back
    cur_req = "R4";
    xfer(0, T_NSEQ, 6'h04, 1'b1, 3'd2, 32'hA1B2C3D4);
    xfer(0, T_NSEQ, 6'h09, 1'b1, 3'd0, 32'h0000EE00);
    xfer(0, T_NSEQ, 6'h0E, 1'b1, 3'd1, 32'h77660000);
    idle_bus();
    rd_chk(0, 6'h04, 32'hA1B2C3D4, "R5");
    rd_chk(0, 6'h08, 32'h0000EE00, "R4 byte");
    rd_chk(0, 6'h0C, 32'h77660000, "R4 half");

    // R6: pipelined writes then reads, no idle in between
    cur_req = "R6";
    xfer(0, T_NSEQ, 6'h10, 1'b1, 3'd2, 32'h11111111);
    xfer(0, T_NSEQ, 6'h14, 1'b1, 3'd2, 32'h22222222);
    chk("R6 write zero wait", 32'(waits), 32'h0);
    xfer(0, T_NSEQ, 6'h10, 1'b0, 3'd2, 32'h0);
    xfer(0, T_NSEQ, 6'h14, 1'b0, 3'd2, 32'h0);
    chk("R6 first read", prev_rdata, 32'h11111111);
    idle_bus();
    chk("R6 second read", prev_rdata, 32'h22222222);

    // R7: SEQ refused with two-cycle RETRY, storage kept
    cur_req = "R7";
    xfer(0, T_SEQ, 6'h04, 1'b1, 3'd2, 32'hDEADBEEF);
    idle_bus();
    chk("R7 first beat resp", 32'(first_resp), 32'h2);
    chk("R7 low beats", 32'(waits), 32'h1);
    chk("R7 second beat resp", 32'(prev_resp), 32'h2);
    rd_chk(0, 6'h04, 32'hA1B2C3D4, "R7 store kept");

    // R3: selected IDLE and BUSY, zero wait, no storage access
    cur_req = "R3";
    xfer(0, T_IDLE, 6'h04, 1'b1, 3'd2, 32'h55555555);
    xfer(0, T_BUSY, 6'h04, 1'b1, 3'd2, 32'h55555555);
    chk("R3 idle waits", 32'(waits), 32'h0);
    idle_bus();
    chk("R3 busy waits", 32'(waits), 32'h0);
    chk("R3 busy resp", 32'(prev_resp), 32'h0);
    rd_chk(0, 6'h04, 32'hA1B2C3D4, "R3 store kept");
    rd_chk(0, 6'h30, 32'h0, "R3 unselected");

    // R11: BUSY directly followed by IDLE
    cur_req = "R11";
    xfer(0, T_NSEQ, 6'h04, 1'b0, 3'd2, 32'h0);
    xfer(0, T_BUSY, 6'h04, 1'b0, 3'd2, 32'h0);
    xfer(0, T_IDLE, 6'h04, 1'b0, 3'd2, 32'h0);
    chk("R11 busy waits", 32'(waits), 32'h0);
    chk("R11 busy resp", 32'(prev_resp), 32'h0);
    idle_bus();
    chk("R11 idle waits", 32'(waits), 32'h0);
    chk("R11 idle resp", 32'(prev_resp), 32'h0);

    // R2: a write presented only while the bus is stalled is never taken
    cur_req = "R2";
    @(negedge clk);
    stall = 1'b1; sel_bus = 3'b001; trans = T_NSEQ; write = 1'b1;
    addr = 6'h04; size = 3'd2; wdata = 32'h99999999;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 readyout held", 32'(ro[0]), 32'h1);
      chk("R2 resp held", 32'(rs[0]), 32'h0);
    end
    sel_bus = '0; trans = T_IDLE; write = 1'b0; stall = 1'b0;
    @(posedge clk);
    rd_chk(0, 6'h04, 32'hA1B2C3D4, "R2 store kept");

    // R10 / R8: wait states and ERROR refusal on target 1
    cur_req = "R10";
    xfer(1, T_NSEQ, 6'h20, 1'b1, 3'd2, 32'hCAFEF00D);
    idle_bus();
    chk("R10 wait cycles", 32'(waits), 32'h2);
    chk("R10 resp", 32'(prev_resp), 32'h0);
    rd_chk(1, 6'h20, 32'hCAFEF00D, "R10");
    cur_req = "R8";
    xfer(1, T_SEQ, 6'h20, 1'b1, 3'd2, 32'h0);
    idle_bus();
    chk("R8 first beat resp", 32'(first_resp), 32'h1);
    chk("R8 low beats", 32'(waits), 32'h1);
    chk("R8 second beat resp", 32'(prev_resp), 32'h1);
    rd_chk(1, 6'h20, 32'hCAFEF00D, "R8 store kept");

    // R9: SEQ performed on target 2
    cur_req = "R9";
    xfer(2, T_SEQ, 6'h30, 1'b1, 3'd2, 32'h0BADCAFE);
    xfer(2, T_SEQ, 6'h34, 1'b1, 3'd1, 32'h0000BEEF);
    chk("R9 wait cycles", 32'(waits), 32'h1);
    idle_bus();
    chk("R9 resp", 32'(prev_resp), 32'h0);
    rd_chk(2, 6'h30, 32'h0BADCAFE, "R9 word");
    rd_chk(2, 6'h34, 32'h0000BEEF, "R9 half");
    rd_chk(0, 6'h30, 32'h0, "R9 other target kept");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule